// File: doc/BRIEF.md
# Sequential Access Buffer RAM Port

This block gives a host processor byte access to an on-chip buffer RAM of 2048 x 8 bits through only three registers: a high pointer register, a low pointer register and a data window. The host first writes the high pointer register. That write sets the transfer direction, the auto-step option and the top address bits. The host then writes the low pointer register with the bottom address byte. After that, every access to the data window reads or writes the RAM byte at the pointer.

With auto-step enabled, the pointer advances by one after each accepted data access and wraps at the top of the RAM. A whole buffer can therefore be streamed through one register address. The direction is chosen when the pointer is loaded. In read direction, a write of the low pointer register fetches the addressed byte into the RAM's output latch at once. Each auto-stepping read also fetches the next byte in the same clock edge. As a result, data reads can be issued on every clock cycle with no wait.

The host interface is synchronous. A strobe counts only while chip select is high, and it acts at the rising clock edge where it is sampled. Read data is registered and appears after that edge.

Top module: `seq_ram_port`

## Requirements
- R1: After synchronous reset, the pointer is 0, the direction is write, auto-step is off, and `host_rdata` is 0x00.
- R2: `host_sel` picks the register: 0 is the data window, 1 is the high pointer register, 2 is the low pointer register. A read of code 3 returns 0x00 and a write to code 3 changes nothing. While `host_cs` is low, strobes change neither the pointer nor `host_rdata`.
- R3: In a high pointer register write, bit 7 sets the direction (1 = read, 0 = write), bit 6 enables auto-step, and bits 2..0 become address bits 10..8. Bits 5..3 are discarded, and they read back as 0.
- R4: A low pointer register write sets address bits 7..0. A read of either pointer register returns the current pointer, including all auto-steps, in `host_rdata` after the edge that sampled the read.
- R5: A low pointer register write while the direction is read fetches the byte at the new address. The next data read returns that byte, even when it comes in the very next cycle.
- R6: A data write in write direction stores `host_wdata` at the pointer. With auto-step on, the pointer then advances by one.
- R7: A data read in read direction returns the fetched byte. With auto-step on, the pointer advances and the byte at the new pointer is fetched in the same edge, so data reads in consecutive cycles return consecutive bytes.
- R8: With auto-step off, data accesses leave the pointer unchanged. Repeated reads return the same byte, and repeated writes overwrite the same address.
- R9: The pointer wraps from 2047 to 0 when it steps, in both directions.
- R10: A data write while the direction is read leaves the RAM and the pointer unchanged. A data read while the direction is write returns 0x00 and leaves the pointer unchanged.
- R11: A high pointer register write starts no fetch. A following data read returns the byte fetched before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Chip select; strobes count only while it is high |
| host_sel | input | 2 | Register select: 0 data, 1 pointer high, 2 pointer low, 3 unused |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |

## Verification
Two functions fall into the same clock edge. In one edge, an auto-stepping data read hands the fetched byte to `host_rdata`, advances the pointer and fetches the byte at the new pointer into the same RAM output register. The bench provokes this by holding the read strobe high for many consecutive cycles. These runs include one that starts 16 bytes below the top of the RAM and crosses the wrap to 0. Each byte is compared, cycle by cycle, against an arithmetic fill pattern written earlier through auto-stepping writes that also wrapped. A one-cycle late fetch, or a wrong wrap, shows up as a repeated or shifted byte.

// File: rtl/seqram_pkg.sv
package seqram_pkg;

  // Host register select codes
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_PHI  = 2'd1,
    SEL_PLO  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

endpackage

// File: rtl/seqram_regs.sv
// Pointer and control registers, strobe decode, RAM port control.
module seqram_regs #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs,
  input  seqram_pkg::sel_e    sel,
  input  logic                rd,
  input  logic                wr,
  input  logic [DW-1:0]       wdata,
  output logic [AW-1:0]       ptr,
  output logic                dir_rd,
  output logic                auto_inc,
  output logic                host_rd,
  output logic                data_rd_ok,
  output logic                mem_we,
  output logic [AW-1:0]       mem_waddr,
  output logic [DW-1:0]       mem_wdata,
  output logic                mem_re,
  output logic [AW-1:0]       mem_raddr
);
  import seqram_pkg::*;

  localparam int HI_W    = AW - DW;
  localparam int DIR_BIT = DW - 1;
  localparam int AI_BIT  = DW - 2;

  logic          host_wr;
  logic          wr_hi, wr_lo, data_wr_ok, step;
  logic [AW-1:0] ptr_inc, ptr_nxt;
  logic          unused_rsvd;

  assign host_rd    = cs & rd & ~wr;
  assign host_wr    = cs & wr & ~rd;
  assign wr_hi      = host_wr & (sel == SEL_PHI);
  assign wr_lo      = host_wr & (sel == SEL_PLO);
  assign data_wr_ok = host_wr & (sel == SEL_DATA) & ~dir_rd;
  assign data_rd_ok = host_rd & (sel == SEL_DATA) & dir_rd;
  assign step       = (data_wr_ok | data_rd_ok) & auto_inc;
  assign ptr_inc    = ptr + AW'(1);

  // reserved control bits carry no function
  assign unused_rsvd = ^wdata[AI_BIT-1:HI_W];

  always_comb begin
    ptr_nxt = ptr;
    if (wr_hi) ptr_nxt[AW-1:DW] = wdata[HI_W-1:0];
    if (wr_lo) ptr_nxt[DW-1:0]  = wdata;
    if (step)  ptr_nxt          = ptr_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      dir_rd   <= 1'b0;
      auto_inc <= 1'b0;
    end else begin
      ptr <= ptr_nxt;
      if (wr_hi) begin
        dir_rd   <= wdata[DIR_BIT];
        auto_inc <= wdata[AI_BIT];
      end
    end
  end

  // Fetch at the pointer value that becomes current at this edge
  assign mem_re    = (wr_lo & dir_rd) | (data_rd_ok & auto_inc);
  assign mem_raddr = ptr_nxt;
  assign mem_we    = data_wr_ok;
  assign mem_waddr = ptr;
  assign mem_wdata = wdata;

endmodule

// File: rtl/seqram_mem.sv
// Simple dual-port RAM with registered, enabled read (block RAM style).
module seqram_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) dout <= mem[raddr];
  end

endmodule

// File: rtl/seqram_rdport.sv
// Registered host read data multiplexer.
module seqram_rdport #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_rd,
  input  seqram_pkg::sel_e sel,
  input  logic             data_rd_ok,
  input  logic [DW-1:0]    fetched,
  input  logic [AW-1:0]    ptr,
  input  logic             dir_rd,
  input  logic             auto_inc,
  output logic [DW-1:0]    rdata
);
  import seqram_pkg::*;

  localparam int HI_W  = AW - DW;
  localparam int PAD_W = DW - 2 - HI_W;

  logic [DW-1:0] rdata_nxt;

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_nxt = data_rd_ok ? fetched : '0;
      SEL_PHI:  rdata_nxt = {dir_rd, auto_inc, {PAD_W{1'b0}}, ptr[AW-1:DW]};
      SEL_PLO:  rdata_nxt = ptr[DW-1:0];
      default:  rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (host_rd) rdata <= rdata_nxt;
  end

endmodule

// File: rtl/seq_ram_port.sv
// Host sequential access port onto a buffer RAM.
module seq_ram_port #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_cs,
  input  logic [1:0]    host_sel,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  import seqram_pkg::*;

  sel_e          sel;
  logic [AW-1:0] ptr_q;
  logic          dir_q, ai_q;
  logic          rd_acc, data_rd_ok;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, fetched;

  assign sel = sel_e'(host_sel);

  seqram_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cs         (host_cs),
    .sel        (sel),
    .rd         (host_rd),
    .wr         (host_wr),
    .wdata      (host_wdata),
    .ptr        (ptr_q),
    .dir_rd     (dir_q),
    .auto_inc   (ai_q),
    .host_rd    (rd_acc),
    .data_rd_ok (data_rd_ok),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_re     (mem_re),
    .mem_raddr  (mem_raddr)
  );

  seqram_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .dout  (fetched)
  );

  seqram_rdport #(.AW(AW), .DW(DW)) u_rdport (
    .clk        (clk),
    .rst        (rst),
    .host_rd    (rd_acc),
    .sel        (sel),
    .data_rd_ok (data_rd_ok),
    .fetched    (fetched),
    .ptr        (ptr_q),
    .dir_rd     (dir_q),
    .auto_inc   (ai_q),
    .rdata      (host_rdata)
  );

endmodule

// File: rtl/seqram_chk.sv
// Protocol checker, bound to the top module.
module seqram_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic [1:0]    sel,
  input logic          rd,
  input logic          wr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [AW-1:0] ptr,
  input logic          dir_rd,
  input logic          auto_inc
);
  localparam int HI_W = AW - DW;

  logic acc_rd, acc_wr, drd, dwr;
  assign acc_rd = cs && rd && !wr;
  assign acc_wr = cs && wr && !rd;
  assign drd    = acc_rd && (sel == 2'd0);
  assign dwr    = acc_wr && (sel == 2'd0);

  AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
    (drd && dir_rd && auto_inc) |=> ptr == AW'($past(ptr) + AW'(1))); // R7

  AST_WR_STEP: assert property (@(posedge clk) disable iff (rst)
    (dwr && !dir_rd && auto_inc) |=> ptr == AW'($past(ptr) + AW'(1))); // R6

  AST_NOSTEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((drd || dwr) && !auto_inc) |=> $stable(ptr)); // R8

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((&ptr) && auto_inc && ((drd && dir_rd) || (dwr && !dir_rd))) |=> ptr == '0); // R9

  AST_BAD_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((dwr && dir_rd) || (drd && !dir_rd)) |=> $stable(ptr)); // R10

  AST_BAD_DIR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (drd && !dir_rd) |=> rdata == '0); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && sel == 2'd1) |=> rdata[DW-3:HI_W] == '0); // R3

  AST_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && sel == 2'd2) |=> ptr[DW-1:0] == $past(wdata)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cs |=> ($stable(ptr) && $stable(rdata))); // R2

endmodule

bind seq_ram_port seqram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs       (host_cs),
  .sel      (host_sel),
  .rd       (host_rd),
  .wr       (host_wr),
  .wdata    (host_wdata),
  .rdata    (host_rdata),
  .ptr      (ptr_q),
  .dir_rd   (dir_q),
  .auto_inc (ai_q)
);

// File: tb/tb_seq_ram_port.sv
module tb_seq_ram_port;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_cs = 1'b0;
  logic [1:0]    host_sel = 2'd0;
  logic          host_rd = 1'b0;
  logic          host_wr = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  seq_ram_port #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_sel(host_sel),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13 + (a >> 8) * 7 + 5) & 255);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One strobe cycle; on return the edge has passed and rdata is settled
  task automatic bus(input logic c, input logic [1:0] s, input logic r,
                     input logic w, input logic [7:0] d);
    @(negedge clk);
    host_cs = c; host_sel = s; host_rd = r; host_wr = w; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [7:0] d);
    bus(1'b1, s, 1'b0, 1'b1, d);
  endtask

  task automatic rreg(input logic [1:0] s, output logic [7:0] v);
    bus(1'b1, s, 1'b1, 1'b0, 8'h00);
    v = host_rdata;
  endtask

  // Reads on consecutive cycles, starting at address a0
  task automatic stream_rd(input string req, input int a0, input int n);
    @(negedge clk);
    host_cs = 1'b1; host_sel = 2'd0; host_rd = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, host_rdata, pat((a0 + i) % DEPTH));
    end
    host_cs = 1'b0; host_rd = 1'b0;
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
      end
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", host_rdata, 8'h00);
    rreg(2'd1, v); check("R1 pointer high after reset", v, 8'h00);
    rreg(2'd2, v); check("R1 pointer low after reset", v, 8'h00);

    // R3: reserved bits dropped; write direction, auto-step on
    wreg(2'd1, 8'h78);
    rreg(2'd1, v); check("R3 reserved bits read zero", v, 8'h40);
    wreg(2'd2, 8'h00);

    // R6 R9: fill entire RAM with auto-step writes; pointer wraps to 0
    for (int a = 0; a < DEPTH; a++) wreg(2'd0, pat(a));
    rreg(2'd2, v); check("R9 write wrap pointer low", v, 8'h00);
    rreg(2'd1, v); check("R9 write wrap pointer high", v, 8'h40);

    // R5 R7 R9: prefetch at 2032, stream across wrap
    wreg(2'd1, 8'hC7);
    wreg(2'd2, 8'hF0);
    stream_rd("R7 R9 stream across wrap", 2032, 32);
    rreg(2'd2, v); check("R4 pointer low after steps", v, 8'h10);
    rreg(2'd1, v); check("R4 pointer high after steps", v, 8'hC0);

    // R7: exhaustive read of every address in consecutive cycles
    stream_rd("R7 exhaustive stream", 16, DEPTH);

    // R5: read in the cycle right after the low write
    wreg(2'd1, 8'hC2);
    @(negedge clk);
    host_cs = 1'b1; host_sel = 2'd2; host_wr = 1'b1; host_wdata = 8'h55;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b1; host_sel = 2'd0;
    @(negedge clk);
    host_cs = 1'b0; host_rd = 1'b0;
    check("R5 immediate read after prefetch", host_rdata, pat(16'h255));

    // R8: no auto-step, repeated reads
    wreg(2'd1, 8'h83);
    wreg(2'd2, 8'h21);
    for (int k = 0; k < 3; k++) begin
      rreg(2'd0, v); check("R8 repeated read same byte", v, pat(16'h321));
    end
    rreg(2'd2, v); check("R8 pointer held on reads", v, 8'h21);

    // R11: high write starts no fetch
    wreg(2'd1, 8'h85);
    rreg(2'd0, v); check("R11 no fetch on high write", v, pat(16'h321));
    rreg(2'd1, v); check("R11 high readback", v, 8'h85);

    // R10: write in read direction is ignored
    wreg(2'd2, 8'h21);
    wreg(2'd0, 8'hAA);
    rreg(2'd2, v); check("R10 pointer held on bad write", v, 8'h21);
    wreg(2'd2, 8'h21);
    rreg(2'd0, v); check("R10 RAM unchanged by bad write", v, pat(16'h521));

    // R10: read in write direction returns zero
    wreg(2'd1, 8'h45);
    wreg(2'd2, 8'h21);
    rreg(2'd0, v); check("R10 bad read returns zero", v, 8'h00);
    rreg(2'd2, v); check("R10 pointer held on bad read", v, 8'h21);

    // R8: no auto-step, repeated writes overwrite one address
    wreg(2'd1, 8'h05);
    wreg(2'd2, 8'h30);
    wreg(2'd0, 8'h11);
    wreg(2'd0, 8'h22);
    rreg(2'd2, v); check("R8 pointer held on writes", v, 8'h30);
    wreg(2'd1, 8'h85);
    wreg(2'd2, 8'h30);
    rreg(2'd0, v); check("R8 last write kept", v, 8'h22);
    wreg(2'd2, 8'h31);
    rreg(2'd0, v); check("R8 neighbour untouched", v, pat(16'h531));

    // R2: unused select code and chip select gating
    rreg(2'd3, v); check("R2 unused code reads zero", v, 8'h00);
    wreg(2'd3, 8'hFF);
    rreg(2'd2, v); check("R2 unused write no effect", v, 8'h31);
    bus(1'b0, 2'd2, 1'b0, 1'b1, 8'h99);
    rreg(2'd2, v); check("R2 deselected write ignored", v, 8'h31);
    bus(1'b0, 2'd1, 1'b1, 1'b0, 8'h00);
    check("R2 deselected read keeps rdata", host_rdata, 8'h31);

    // R1: reset again restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 rdata after second reset", host_rdata, 8'h00);
    rreg(2'd1, v); check("R1 control cleared", v, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule